// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is an I2C target that sits in front of a small byte-addressed register space. It watches SCL and SDA through a synchronizer clocked by a faster system clock. It finds START, repeated START and STOP conditions, and it answers one fixed 7-bit address. It pulls SDA low through an output-enable, so the pad is driven open-drain.

An internal pointer selects the register. In a write transfer, the first byte after the address loads the pointer. Each later byte is written to the register at the pointer, and the pointer then steps by one. In a read transfer, the block sends bytes starting at the pointer and steps the pointer after each one. The pointer keeps its value between transfers. A controller can therefore read on from where the last access stopped. It can also set the pointer and then read, using a repeated START in between. Storage is outside the block, on a simple synchronous register-file port: a one-cycle write strobe and a read that returns data one clock after the address.

Top module: `i2c_ptr_target`

## Requirements
- R1: The target acknowledges (holds SDA low on the ninth clock) only an address byte whose upper seven bits are 1101000; bit 0 of that byte is the direction, 0 = write and 1 = read. For any other address it sends no ACK, never drives SDA and writes nothing until the next START.
- R2: In a write transfer, the first byte after the address is loaded into the register pointer and is acknowledged.
- R3: Each further byte of a write transfer is acknowledged and is written to the register at the pointer: `reg_we` is high for exactly one system clock, with `reg_addr` equal to the pointer, and this happens while SCL is low after the eighth bit. The pointer then increases by one.
- R4: The pointer is 6 bits wide, so a step from 63 goes to 0. This holds for both writes and reads.
- R5: In a read transfer, the target sends the byte stored at the pointer, MSB first, and the pointer advances by one for each byte it loads for sending.
- R6: The pointer keeps its value across transfers. A read with no pointer write before it starts at the pointer's last value. A write transfer with zero data bytes only sets the pointer.
- R7: A NACK from the controller after a read byte ends the transmission. The target leaves SDA released until STOP or START, and the next read continues at the byte after the last one sent.
- R8: A repeated START ends the current transfer and begins a new address phase, so a pointer write followed by a repeated-START read returns data from the new pointer.
- R9: A START or STOP at any point clears the bit and byte state. A STOP in the middle of a data byte writes nothing.
- R10: After reset, `sda_oe`, `reg_we` and `reg_addr` are 0. `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND bus) |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_we | output | 1 | One-cycle write strobe to storage |
| reg_addr | output | PTR_W | Register pointer, used for both reads and writes |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid one clock after `reg_addr` |

## Verification
The bench drives the block through several transfer patterns:
- a multi-byte write;
- a read with no pointer write first, which shows whether the pointer persisted;
- a pointer write then a repeated-START read, which separates repeated START from a fresh transfer;
- a transfer to a wrong address, which must leave both bus and storage untouched;
- a write that crosses register 63, which exposes wrap handling;
- a STOP cut into a data byte, which shows whether partial bytes leak into storage;
- a zero-data write, which sets only the pointer.

Back-to-back reads ended by NACK check that the pointer is stepped once per byte sent, neither skipped nor repeated.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WR,
    ST_ACK,
    ST_TX,
    ST_RACK,
    ST_IGN
  } tgt_state_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_lvl;
  logic scl_q;
  logic sda_q;

  generate
    if (STAGES < 2) begin : g_one
      logic scl_r, sda_r;
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_r <= 1'b1;
          sda_r <= 1'b1;
        end else begin
          scl_r <= scl_in;
          sda_r <= sda_in;
        end
      end
      assign scl_lvl = scl_r;
      assign sda_lvl = sda_r;
    end else begin : g_chain
      logic [STAGES-1:0] scl_sh, sda_sh;
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[STAGES-2:0], scl_in};
          sda_sh <= {sda_sh[STAGES-2:0], sda_in};
        end
      end
      assign scl_lvl = scl_sh[STAGES-1];
      assign sda_lvl = sda_sh[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_lvl;
      sda_q <= sda_lvl;
    end
  end

  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'b1101000,
  parameter int         PTR_W       = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic              reg_we,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata
);
  localparam int              CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL    = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

  tgt_state_t        state, nxt;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] rxsh, txsh;
  logic [PTR_W-1:0]  ptr;
  logic              mack;

  assign reg_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      nxt       <= ST_IDLE;
      bitcnt    <= '0;
      rxsh      <= '0;
      txsh      <= '0;
      ptr       <= '0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (reg_we) ptr <= ptr + PTR_ONE;

      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_PTR, ST_WR: begin
            if (scl_rise && bitcnt < FULL) begin
              rxsh   <= {rxsh[BYTE_W-2:0], sda_lvl};
              bitcnt <= bitcnt + CNT_ONE;
            end else if (scl_fall && bitcnt == FULL) begin
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (rxsh[BYTE_W-1:1] == TARGET_ADDR) begin
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                  nxt    <= rxsh[0] ? ST_TX : ST_PTR;
                end else begin
                  state <= ST_IGN;
                end
              end else if (state == ST_PTR) begin
                ptr    <= rxsh[PTR_W-1:0];
                sda_oe <= 1'b1;
                state  <= ST_ACK;
                nxt    <= ST_WR;
              end else begin
                reg_we    <= 1'b1;
                reg_wdata <= rxsh;
                sda_oe    <= 1'b1;
                state     <= ST_ACK;
                nxt       <= ST_WR;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (nxt == ST_TX) begin
                sda_oe <= ~reg_rdata[BYTE_W-1];
                txsh   <= {reg_rdata[BYTE_W-2:0], 1'b0};
                ptr    <= ptr + PTR_ONE;
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= nxt;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + CNT_ONE;
            end else if (scl_fall) begin
              if (bitcnt == FULL) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                state  <= ST_RACK;
              end else begin
                sda_oe <= ~txsh[BYTE_W-1];
                txsh   <= {txsh[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack) begin
                sda_oe <= ~reg_rdata[BYTE_W-1];
                txsh   <= {reg_rdata[BYTE_W-2:0], 1'b0};
                ptr    <= ptr + PTR_ONE;
                bitcnt <= '0;
                state  <= ST_TX;
              end else begin
                state <= ST_IGN;
              end
            end
          end
          default: begin
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'b1101000,
  parameter int         PTR_W       = 6,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              reg_we,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_i),
    .sda_in   (sda_i),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_tgt_ctrl #(.TARGET_ADDR(TARGET_ADDR), .PTR_W(PTR_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .reg_rdata(reg_rdata),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata)
  );
endmodule

// File: rtl/i2c_ptr_target_chk.sv
module i2c_ptr_target_chk #(
  parameter int PTR_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_i,
  input logic             sda_oe,
  input logic             reg_we,
  input logic [PTR_W-1:0] reg_addr
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i); // R10

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sda_oe && !reg_we && reg_addr == '0)); // R10

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we); // R3

  AST_WE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> !scl_i); // R3

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> (reg_addr == $past(reg_addr) + PTR_W'(1))); // R4
endmodule

bind i2c_ptr_target i2c_ptr_target_chk #(.PTR_W(PTR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .scl_i   (scl_i),
  .sda_oe  (sda_oe),
  .reg_we  (reg_we),
  .reg_addr(reg_addr)
);

// File: tb/test_i2c_ptr_target.sv
module test_i2c_ptr_target;
  localparam int H = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe, reg_we, sda_bus;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  assign sda_bus = ~(sda_oe | m_low);

  i2c_ptr_target i_i2c_ptr_target (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic int pat(int i);
    return (i * 37 + 11) % 256;
  endfunction

  logic [7:0] mem [64];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'(pat(i));
      reg_rdata <= '0;
    end else begin
      if (reg_we) mem[reg_addr] <= reg_wdata;
      reg_rdata <= mem[reg_addr];
    end
  end

  int total = 0, bad = 0;
  int mdl [64];
  int mptr = 0;
  int exp_q [$];
  int dq [$];
  bit quiet = 0, done = 0;
  logic prev_oe = 1'b0;

  function automatic void check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endfunction

  // per-clock comparison against the behavioural model
  always @(negedge clk) begin
    if (!rst) begin
      if (reg_we) begin
        if (exp_q.size() == 0) check(0, "R3 unexpected write", reg_addr * 256 + reg_wdata, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(reg_addr * 256 + reg_wdata == e, "R3 write addr/data", reg_addr * 256 + reg_wdata, e);
        end
      end
      if (quiet && sda_oe) check(0, "R1/R7 SDA driven while it must be released", 1, 0);
      if (sda_oe != prev_oe && m_scl) check(0, "R10 SDA changed while SCL high", sda_oe, prev_oe);
      prev_oe = sda_oe;
    end
  end

  task automatic hc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c();
    m_low = 0; hc(H); m_scl = 1; hc(H); m_low = 1; hc(H); m_scl = 0; hc(4);
  endtask

  task automatic stop_c();
    m_low = 1; hc(H); m_scl = 1; hc(H); m_low = 0; hc(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; hc(H); m_scl = 1; hc(H); m_scl = 0; hc(4);
    end
    m_low = 0; hc(H); m_scl = 1; hc(H/2); ack = ~sda_bus; hc(H/2); m_scl = 0; hc(4);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_low = 0; hc(H); m_scl = 1; hc(H/2); b[i] = sda_bus; hc(H/2); m_scl = 0; hc(4);
    end
    m_low = give_ack; hc(H); m_scl = 1; hc(H); m_scl = 0; hc(4); m_low = 0;
  endtask

  task automatic wr_txn(input int p);
    logic ack;
    start_c();
    send_byte(8'hD0, ack); check(ack, "R1 write address ACK", ack, 1);
    send_byte(8'(p), ack); check(ack, "R2 pointer byte ACK", ack, 1);
    mptr = p;
    foreach (dq[k]) begin
      exp_q.push_back(mptr * 256 + dq[k]);
      mdl[mptr] = dq[k];
      send_byte(8'(dq[k]), ack); check(ack, "R3 data byte ACK", ack, 1);
      mptr = (mptr + 1) % 64;
    end
    stop_c(); hc(8);
    check(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);
  endtask

  task automatic read_bytes(input int n, input string req);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      check(int'(b) == mdl[mptr], {req, " R5 read byte"}, b, mdl[mptr]);
      mptr = (mptr + 1) % 64;
    end
    quiet = 1;
    stop_c(); hc(4);
    quiet = 0;
  endtask

  task automatic rd_txn(input int n, input string req);
    logic ack;
    start_c();
    send_byte(8'hD1, ack); check(ack, "R1 read address ACK", ack, 1);
    read_bytes(n, req);
  endtask

  task automatic ptr_rd_txn(input int p, input int n);
    logic ack;
    start_c();
    send_byte(8'hD0, ack); check(ack, "R1 write address ACK", ack, 1);
    send_byte(8'(p), ack); check(ack, "R2 pointer byte ACK", ack, 1);
    mptr = p;
    start_c();
    send_byte(8'hD1, ack); check(ack, "R8 address ACK after repeated START", ack, 1);
    read_bytes(n, "R8");
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = pat(i);
    hc(5);
    rst = 0;
    hc(1);
    check(sda_oe == 0 && reg_we == 0, "R10 reset outputs idle", {sda_oe, reg_we}, 0);
    check(reg_addr == 0, "R10 reset pointer", reg_addr, 0);

    dq = {8'hA1, 8'hB2, 8'hC3};
    wr_txn(5);                         // R2 R3
    rd_txn(2, "R6 no pointer write");  // continues at 8

    ptr_rd_txn(3, 3);                  // R8

    begin : wrong_addr                 // R1 ignored address
      logic ack;
      start_c();
      send_byte(8'h50, ack); check(!ack, "R1 wrong address NACK", ack, 0);
      quiet = 1;
      send_byte(8'h07, ack); check(!ack, "R1 ignored byte NACK", ack, 0);
      send_byte(8'h99, ack); check(!ack, "R1 ignored byte NACK", ack, 0);
      stop_c(); hc(4);
      quiet = 0;
    end
    rd_txn(1, "R1 R6 pointer untouched by other address");

    dq = {8'h11, 8'h22, 8'h33, 8'h44};
    wr_txn(62);                        // R4 wrap on write
    rd_txn(2, "R4 wrap");

    begin : abort_byte                 // R9
      logic ack;
      start_c();
      send_byte(8'hD0, ack); check(ack, "R1 write address ACK", ack, 1);
      send_byte(8'd10, ack); check(ack, "R2 pointer byte ACK", ack, 1);
      mptr = 10;
      for (int i = 0; i < 4; i++) begin
        m_low = 0; hc(H); m_scl = 1; hc(H); m_scl = 0; hc(4);
      end
      stop_c(); hc(8);
    end
    rd_txn(1, "R9 aborted byte not written");
    rd_txn(2, "R7 continue after NACK");

    dq = {};
    wr_txn(20);
    rd_txn(1, "R6 zero-data write sets pointer");

    begin : wrap_read                  // R4 wrap on read
      dq = {};
      wr_txn(63);
      rd_txn(2, "R4 read wrap");
    end

    hc(10);
    done = 1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog expired", 0, 1);
      report();
    end
  end
endmodule